// File: doc/BRIEF.md
# Sound Channel Volume Envelope

This block keeps the 4-bit volume of one sound channel and moves it up or down over time. Software programs a control byte with three fields: a starting volume, a direction and a step period. A trigger strobe restarts the envelope, and an envelope clock strobe, issued by a frame sequencer, drives a countdown that moves the volume by one step each time the countdown expires. The block also reports whether the channel's DAC is powered, and whether the channel is currently playing.

Rewriting the control byte while the channel plays does not just replace the stored fields. It also changes the volume at once. The volume can be inverted, mirrored or stepped, depending on the old and new direction, the old and new period and the lock state. The block reproduces these irregular changes exactly, so that software relying on them hears the expected level. Waveform generation, length timing and mixing belong to other blocks.

Top module: `vol_envelope`

## Requirements
- R1: After reset the volume is 0, the DAC flag is 0 and the channel is inactive.
- R2: The control byte holds the start volume in bits 7:4, the direction in bit 3 (1 = increase) and the period in bits 2:0. The DAC flag is 1 exactly when bits 7:3 of the last write are not all zero. A write that turns the DAC off makes the channel inactive in the next cycle, and a trigger while the DAC is off leaves it inactive.
- R3: With period P not 0, after a trigger the P-th envelope tick requests a step, and the volume changes one cycle after that tick. The countdown then reloads with P. With period 0 envelope ticks never change the volume.
- R4: A step adds 1 while the volume is below 15, or subtracts 1 while it is above 0. When the limit is reached the envelope locks, and later ticks change nothing until the next trigger.
- R5: A trigger loads the volume from bits 7:4, loads the countdown from the period, clears the lock and any pending step, and makes the channel active exactly when the DAC is on.
- R6: A write while active that changes the direction to increase sets the volume to volume XOR 15 when the old period was 0 and the envelope is unlocked, and otherwise to (14 − volume) mod 16. No extra step follows.
- R7: A write while active that changes the direction to decrease sets the volume to (16 − volume) mod 16. An extra step from R8 may follow.
- R8: A write while active takes an extra step, modulo 16, in the new direction in two cases, provided the envelope is unlocked. The first is a new period that is not 0 where the old period was 0. The second is bits 3:0 equal to 0x8 both before and after the write.
- R9: A write in the same cycle as an envelope tick that requests a step reloads the countdown with the new period. If the new period is 0 and no extra step is taken, the requested step is dropped.
- R10: A write while the channel is inactive, or one that turns the DAC off, changes only the stored fields and the DAC flag, not the volume. Envelope ticks while the channel is inactive do not change the volume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_data | input | 8 | Control byte value |
| trig | input | 1 | Trigger strobe, restarts the envelope |
| env_tick | input | 1 | Envelope clock strobe from the frame sequencer |
| volume | output | 4 | Current channel volume |
| dac_en | output | 1 | DAC powered |
| chan_active | output | 1 | Channel playing |

## Verification
The checker watches several rules on every cycle: the DAC flag follows each write, the channel is never active while the DAC is off, and a trigger loads the volume and the activity flag. It also checks that, outside writes and triggers, the volume moves by at most one step and never wraps. In that same case the volume holds still when the envelope is locked, when the period is 0 or when the channel is idle. The exact values of the write glitch cannot be covered by a cycle rule: the inversion, the mirror and the wrap of the extra step. Neither can the period counting, the dropped step or the countdown reload on a write that coincides with a tick. Only the bench's directed scenarios show those, with worked-out volumes.

// File: rtl/venv_pkg.sv
package venv_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/venv_timer.sv
module venv_timer #(
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [PER_W-1:0] period,
  input  logic             trig_load,
  input  logic [PER_W-1:0] trig_val,
  input  logic             wr_reload,
  input  logic [PER_W-1:0] wr_val,
  output logic             step_req
);
  logic [PER_W-1:0] cnt_q, cnt_d, cnt_dec;
  logic             run, cnt_en;

  always_comb begin
    run      = tick && (period != '0);
    cnt_dec  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    step_req = run && active && (cnt_dec == '0);
    cnt_d    = cnt_q;
    if (run)       cnt_d = step_req ? period : cnt_dec;
    if (wr_reload) cnt_d = wr_val;
    if (trig_load) cnt_d = trig_val;
    cnt_en   = run || wr_reload || trig_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/venv_step.sv
module venv_step #(
  parameter int VOL_W = 4
) (
  input  logic             en,
  input  logic             up,
  input  logic [VOL_W-1:0] vol_i,
  input  logic             lock_i,
  output logic [VOL_W-1:0] vol_o,
  output logic             lock_o
);
  import venv_pkg::*;
  localparam logic [VOL_W-1:0] VMAX = '1;
  dir_e dir;

  always_comb begin
    dir    = dir_e'(up);
    vol_o  = vol_i;
    lock_o = lock_i;
    if (en && !lock_i) begin
      if (dir == DIR_UP && vol_i != VMAX)        vol_o = vol_i + 1'b1;
      else if (dir == DIR_DOWN && vol_i != '0)   vol_o = vol_i - 1'b1;
      if ((dir == DIR_UP && vol_o == VMAX) || (dir == DIR_DOWN && vol_o == '0))
        lock_o = 1'b1;
    end
  end
endmodule

// File: rtl/venv_glitch.sv
module venv_glitch #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input  logic [PER_W-1:0] old_per,
  input  logic             old_up,
  input  logic [PER_W-1:0] new_per,
  input  logic             new_up,
  input  logic [VOL_W-1:0] vol_i,
  input  logic             locked,
  input  logic             pending,
  output logic [VOL_W-1:0] vol_o,
  output logic             reload,
  output logic             cancel
);
  import venv_pkg::*;
  localparam logic [VOL_W-1:0] VMAX = '1;
  localparam logic [VOL_W-1:0] VMIR = VMAX - 1'b1;
  logic extra;
  logic [VOL_W-1:0] v;
  dir_e odir, ndir;

  always_comb begin
    odir  = dir_e'(old_up);
    ndir  = dir_e'(new_up);
    extra = !locked && (((new_per != '0) && (old_per == '0)) ||
            ((ndir == DIR_UP) && (new_per == '0) && (odir == DIR_UP) && (old_per == '0)));
    v = vol_i;
    if (odir != ndir) begin
      if (ndir == DIR_UP) begin
        v     = ((old_per == '0) && !locked) ? (vol_i ^ VMAX) : (VMIR - vol_i);
        extra = 1'b0;
      end else begin
        v = '0 - vol_i;
      end
    end
    if (extra) v = (ndir == DIR_UP) ? v + 1'b1 : v - 1'b1;
    vol_o  = v;
    reload = pending;
    cancel = pending && !extra && (new_per == '0);
  end
endmodule

// File: rtl/vol_envelope.sv
module vol_envelope #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_wr,
  input  logic [VOL_W+PER_W:0]   ctrl_data,
  input  logic                   trig,
  input  logic                   env_tick,
  output logic [VOL_W-1:0]       volume,
  output logic                   dac_en,
  output logic                   chan_active
);
  localparam int CTRL_W = VOL_W + PER_W + 1;
  localparam int DIR_B  = PER_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_b;
  logic [VOL_W-1:0]  vol_q, vol_d, vol_a, vol_g;
  logic              lock_q, lock_d, lock_a;
  logic              pend_q, pend_d;
  logic              act_q, act_d;
  logic              step_req, g_reload, g_cancel;
  logic              new_dac, glitch_en;
  logic              vol_en, lock_en, act_en;

  venv_step #(.VOL_W(VOL_W)) u_step (
    .en(pend_q), .up(ctrl_q[DIR_B]), .vol_i(vol_q), .lock_i(lock_q),
    .vol_o(vol_a), .lock_o(lock_a)
  );

  venv_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(env_tick), .active(act_q),
    .period(ctrl_q[PER_W-1:0]),
    .trig_load(trig), .trig_val(ctrl_b[PER_W-1:0]),
    .wr_reload(glitch_en && g_reload), .wr_val(ctrl_data[PER_W-1:0]),
    .step_req(step_req)
  );

  venv_glitch #(.VOL_W(VOL_W), .PER_W(PER_W)) u_glitch (
    .old_per(ctrl_q[PER_W-1:0]), .old_up(ctrl_q[DIR_B]),
    .new_per(ctrl_data[PER_W-1:0]), .new_up(ctrl_data[DIR_B]),
    .vol_i(vol_a), .locked(lock_a), .pending(step_req),
    .vol_o(vol_g), .reload(g_reload), .cancel(g_cancel)
  );

  always_comb begin
    new_dac   = |ctrl_data[CTRL_W-1:DIR_B];
    glitch_en = ctrl_wr && act_q && new_dac;
    ctrl_b    = ctrl_wr ? ctrl_data : ctrl_q;
    vol_d     = glitch_en ? vol_g : vol_a;
    lock_d    = lock_a;
    pend_d    = step_req && !(glitch_en && g_cancel);
    act_d     = (ctrl_wr && !new_dac) ? 1'b0 : act_q;
    if (trig) begin
      vol_d  = ctrl_b[CTRL_W-1:DIR_B+1];
      lock_d = 1'b0;
      pend_d = 1'b0;
      act_d  = |ctrl_b[CTRL_W-1:DIR_B];
    end
    vol_en  = pend_q || glitch_en || trig;
    lock_en = pend_q || trig;
    act_en  = ctrl_wr || trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vol_q <= '0;
    else if (vol_en) vol_q <= vol_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  assign volume      = vol_q;
  assign dac_en      = |ctrl_q[CTRL_W-1:DIR_B];
  assign chan_active = act_q;
endmodule

// File: rtl/vol_envelope_chk.sv
module vol_envelope_chk #(
  parameter int VOL_W = 4,
  parameter int PER_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctrl_wr,
  input logic [VOL_W+PER_W:0] ctrl_data,
  input logic                 trig,
  input logic [VOL_W-1:0]     volume,
  input logic                 dac_en,
  input logic                 chan_active,
  input logic [VOL_W+PER_W:0] ctrl_q,
  input logic                 lock_q,
  input logic                 pend_q
);
  localparam int CTRL_W = VOL_W + PER_W + 1;
  logic quiet;
  assign quiet = !ctrl_wr && !trig;

  p_dac_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> dac_en == $past(|ctrl_data[CTRL_W-1:PER_W]));

  p_dac_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_en |-> !chan_active);

  p_trig_vol_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> volume == $past(ctrl_wr ? ctrl_data[CTRL_W-1:PER_W+1] : ctrl_q[CTRL_W-1:PER_W+1]));

  p_trig_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> chan_active == dac_en);

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (({1'b0, volume} == {1'b0, $past(volume)}) ||
               ({1'b0, volume} == {1'b0, $past(volume)} + 1'b1) ||
               ({1'b0, volume} + 1'b1 == {1'b0, $past(volume)})));

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && lock_q) |=> $stable(volume));

  p_period0_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !pend_q && ctrl_q[PER_W-1:0] == '0) |=> $stable(volume));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !pend_q && !chan_active) |=> $stable(volume));
endmodule

bind vol_envelope vol_envelope_chk #(.VOL_W(VOL_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .trig(trig),
  .volume(volume), .dac_en(dac_en), .chan_active(chan_active),
  .ctrl_q(ctrl_q), .lock_q(lock_q), .pend_q(pend_q)
);

// File: tb/vol_envelope_test.sv
`timescale 1ns/1ps
module vol_envelope_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic       trig = 1'b0;
  logic       env_tick = 1'b0;
  logic [3:0] volume;
  logic       dac_en, chan_active;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vol_envelope uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .trig(trig), .env_tick(env_tick),
    .volume(volume), .dac_en(dac_en), .chan_active(chan_active)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic t, input logic k);
    @(negedge clk);
    ctrl_wr = w; ctrl_data = d; trig = t; env_tick = k;
    @(negedge clk);
    ctrl_wr = 1'b0; trig = 1'b0; env_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [7:0] d);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    cyc(1'b1, d, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 volume", volume, 0);
    check("R1 dac", dac_en, 0);
    check("R1 active", chan_active, 0);
  endtask

  task automatic t_basic_step;
    start(8'hF1);
    check("R5 trig volume", volume, 15);
    check("R5 trig active", chan_active, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    check("R3 step delayed", volume, 15);
    idle(1);
    check("R3 step applied", volume, 14);
  endtask

  task automatic t_period;
    start(8'h73);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
    check("R3 two ticks of three", volume, 7);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
    check("R3 third tick", volume, 6);
  endtask

  task automatic t_lock;
    start(8'hE9);
    cyc(1'b0, 8'h00, 1'b0, 1'b1); idle(1);
    check("R4 reach max", volume, 15);
    cyc(1'b0, 8'h00, 1'b0, 1'b1); idle(1);
    check("R4 saturate", volume, 15);
    cyc(1'b1, 8'hE1, 1'b0, 1'b0);
    check("R7 invert down", volume, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1); idle(1);
    check("R4 lock holds", volume, 1);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    check("R5 retrigger volume", volume, 14);
    cyc(1'b0, 8'h00, 1'b0, 1'b1); idle(1);
    check("R5 lock cleared", volume, 13);
  endtask

  task automatic t_period0_dac;
    start(8'h80);
    repeat (3) cyc(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
    check("R3 period zero", volume, 8);
    cyc(1'b1, 8'h00, 1'b0, 1'b0);
    check("R2 dac off", dac_en, 0);
    check("R2 inactive", chan_active, 0);
    cyc(1'b1, 8'h08, 1'b0, 1'b0);
    check("R2 bit3 powers dac", dac_en, 1);
    cyc(1'b1, 8'h07, 1'b0, 1'b0);
    check("R2 bits7to3 zero", dac_en, 0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0);
    check("R2 trig with dac off", chan_active, 0);
    check("R5 trig volume dac off", volume, 0);
  endtask

  task automatic t_to_up;
    start(8'h50);
    cyc(1'b1, 8'h58, 1'b0, 1'b0);
    check("R6 xor", volume, 10);
    start(8'h62);
    cyc(1'b1, 8'h6A, 1'b0, 1'b0);
    check("R6 mirror", volume, 8);
    start(8'h40);
    cyc(1'b1, 8'h49, 1'b0, 1'b0);
    check("R6 no extra step", volume, 11);
  endtask

  task automatic t_to_down;
    start(8'h3A);
    cyc(1'b1, 8'h32, 1'b0, 1'b0);
    check("R7 negate", volume, 13);
    start(8'h48);
    cyc(1'b1, 8'h41, 1'b0, 1'b0);
    check("R7 negate then step", volume, 11);
  endtask

  task automatic t_extra;
    start(8'h40);
    cyc(1'b1, 8'h41, 1'b0, 1'b0);
    check("R8 period from zero", volume, 3);
    start(8'h48);
    cyc(1'b1, 8'h48, 1'b0, 1'b0);
    check("R8 nibble 8 first", volume, 5);
    cyc(1'b1, 8'h48, 1'b0, 1'b0);
    check("R8 nibble 8 second", volume, 6);
    start(8'hF8);
    cyc(1'b1, 8'hF8, 1'b0, 1'b0);
    check("R8 wrap", volume, 0);
  endtask

  task automatic t_pending;
    start(8'h91);
    cyc(1'b1, 8'h90, 1'b0, 1'b1);
    idle(1);
    check("R9 step dropped", volume, 9);
    start(8'h91);
    cyc(1'b1, 8'h93, 1'b0, 1'b1);
    idle(1);
    check("R9 step kept", volume, 8);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
    check("R9 reload to new period", volume, 8);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
    check("R9 reload expiry", volume, 7);
  endtask

  task automatic t_inactive;
    start(8'h51);
    cyc(1'b1, 8'h07, 1'b0, 1'b0);
    check("R10 dac off keeps volume", volume, 5);
    cyc(1'b1, 8'h58, 1'b0, 1'b0);
    check("R10 inactive write", volume, 5);
    check("R10 still inactive", chan_active, 0);
    cyc(1'b1, 8'h51, 1'b0, 1'b0);
    repeat (2) cyc(1'b0, 8'h00, 1'b0, 1'b1);
    idle(1);
    check("R10 inactive ticks", volume, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset;
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    t_reset;
    t_basic_step;
    t_period;
    t_lock;
    t_period0_dac;
    t_to_up;
    t_to_down;
    t_extra;
    t_pending;
    t_inactive;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule